// File: doc/BRIEF.md
# Per-CPU Masked Interrupt Router

This block gathers a vector of level-sensitive device interrupt lines into a raw request register and routes them to four processors. Each processor owns a 64-bit enable mask. The processor's hard-interrupt output is high for as long as at least one line that its mask enables is pending.

A second-level legacy interrupt controller cascades into the router through a dedicated input. That input is merged onto raw line 55. Software reaches the block through a 64-bit, little-endian register port. On that port it can:
- program each processor's mask;
- read each processor's masked view (mask AND raw);
- read the raw vector.

The views and the raw vector are read-only. An offset that the port does not decode reads as zero and raises a one-cycle error flag.

Top module: `irq_router`

## Requirements
- R1: Raw request bit i takes the value of `irq_lines[i]` at each clock edge. A line change is visible in the raw vector (offset 0x300) in the cycle after the edge that samples it.
- R2: Raw bit 55 is set while `legacy_irq` is high, whatever `irq_lines[55]` is. When both are low it clears at the next edge.
- R3: A write to the mask offset of a processor replaces that processor's mask with `csr_wdata` and leaves the other three unchanged. The mask offsets are 0x200 (CPU0), 0x240 (CPU1), 0x600 (CPU2) and 0x640 (CPU3). A read at the same offset returns the mask.
- R4: A read at a processor's masked-request offset returns its mask AND the raw vector. These offsets are 0x280 (CPU0), 0x2C0 (CPU1), 0x680 (CPU2) and 0x6C0 (CPU3).
- R5: A read at offset 0x300 returns the raw request vector. Read data is valid in the same cycle as `csr_req` with `csr_we` low. Otherwise it is zero.
- R6: `cpu_irq[n]` is high exactly when CPU n's masked request is nonzero. It follows a mask write or a sampled line change after the same clock edge that updates the register.
- R7: Writes to the masked-request offsets and to the raw offset change no mask and no raw bit.
- R8: An access to any offset other than the nine listed reads zero. This includes offsets whose low three bits are not zero. The access sets `csr_err` high for the one cycle after its clock edge.
- R9: Synchronous reset clears every mask, the raw vector and `csr_err`, so all `cpu_irq` outputs are low.
- R10: Data is little-endian: `csr_wdata`/`csr_rdata` bit k corresponds to interrupt line k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 64 | Level-sensitive device interrupt lines |
| legacy_irq | input | 1 | Cascaded legacy controller request, merged onto line 55 |
| csr_req | input | 1 | Register access strobe, one access per cycle |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | Byte offset within the block |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data, same cycle as the request |
| csr_err | output | 1 | One-cycle flag after an access to an undecoded offset |
| cpu_irq | output | 4 | Hard-interrupt request per processor |

## Verification
The assertions assume that `irq_lines`, `legacy_irq` and the port signals are stable around each rising edge. The bench meets this by changing them only on the falling edge.

The assertions also assume that `csr_wdata` is meaningful only while a write is requested. Each access in the bench is held for exactly one edge, so a mask update and the error pulse are each tied to a single edge.

Interrupt lines are driven from explicit vectors, never from the port. This keeps raw capture independent of register traffic.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int NUM_CPU  = 4;
    localparam int CPU_W    = $clog2(NUM_CPU);
    localparam int OFFS_W   = 12;

    localparam logic [OFFS_W-1:0] OFFS_MASK0 = 12'h200;
    localparam logic [OFFS_W-1:0] OFFS_MASK1 = 12'h240;
    localparam logic [OFFS_W-1:0] OFFS_MASK2 = 12'h600;
    localparam logic [OFFS_W-1:0] OFFS_MASK3 = 12'h640;
    localparam logic [OFFS_W-1:0] OFFS_VIEW0 = 12'h280;
    localparam logic [OFFS_W-1:0] OFFS_VIEW1 = 12'h2C0;
    localparam logic [OFFS_W-1:0] OFFS_VIEW2 = 12'h680;
    localparam logic [OFFS_W-1:0] OFFS_VIEW3 = 12'h6C0;
    localparam logic [OFFS_W-1:0] OFFS_RAW   = 12'h300;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_MASK = 2'd1,
        REG_VIEW = 2'd2,
        REG_RAW  = 2'd3
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [CPU_W-1:0] cpu;
    } reg_sel_t;

    function automatic reg_sel_t decode_offset(input logic [OFFS_W-1:0] offs);
        reg_sel_t s;
        s.kind = REG_NONE;
        s.cpu  = '0;
        unique case (offs)
            OFFS_MASK0: begin s.kind = REG_MASK; s.cpu = 2'd0; end
            OFFS_MASK1: begin s.kind = REG_MASK; s.cpu = 2'd1; end
            OFFS_MASK2: begin s.kind = REG_MASK; s.cpu = 2'd2; end
            OFFS_MASK3: begin s.kind = REG_MASK; s.cpu = 2'd3; end
            OFFS_VIEW0: begin s.kind = REG_VIEW; s.cpu = 2'd0; end
            OFFS_VIEW1: begin s.kind = REG_VIEW; s.cpu = 2'd1; end
            OFFS_VIEW2: begin s.kind = REG_VIEW; s.cpu = 2'd2; end
            OFFS_VIEW3: begin s.kind = REG_VIEW; s.cpu = 2'd3; end
            OFFS_RAW:   begin s.kind = REG_RAW;  s.cpu = 2'd0; end
            default:    begin s.kind = REG_NONE; s.cpu = 2'd0; end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture
    import irq_router_pkg::*;
#(
    parameter int LINES        = 64,
    parameter int CASCADE_LINE = 55
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] lines_in,
    input  logic             cascade_in,
    output logic [LINES-1:0] raw_q
);

    logic [LINES-1:0] merged;

    always_comb begin
        merged = lines_in;
        merged[CASCADE_LINE] = lines_in[CASCADE_LINE] | cascade_in;
    end

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= merged;
    end

    // R2
    cascade_bit_chk: assert property (@(posedge clk) disable iff (rst)
        cascade_in |=> raw_q[CASCADE_LINE]);

endmodule

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [OFFS_W-1:0] addr,
    output reg_sel_t          sel,
    output logic [NUM_CPU-1:0] mask_wr,
    output logic              err_q
);

    always_comb begin
        sel = decode_offset(addr);
        mask_wr = '0;
        if (req && we && sel.kind == REG_MASK)
            mask_wr[sel.cpu] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= req && (sel.kind == REG_NONE);
    end

    // R8
    err_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $past(req));

    // R3
    single_wr_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask_wr));

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_router_pkg::*;
#(
    parameter int LINES = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CPU-1:0] mask_wr,
    input  logic [LINES-1:0]   wdata,
    input  logic [LINES-1:0]   raw_q,
    output logic [LINES-1:0]   mask_q [NUM_CPU],
    output logic [LINES-1:0]   view   [NUM_CPU],
    output logic [NUM_CPU-1:0] irq_out
);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        always_ff @(posedge clk) begin
            if (rst)             mask_q[c] <= '0;
            else if (mask_wr[c]) mask_q[c] <= wdata;
        end

        assign view[c]    = mask_q[c] & raw_q;
        assign irq_out[c] = |view[c];

        // R3
        mask_load_chk: assert property (@(posedge clk) disable iff (rst)
            mask_wr[c] |=> (mask_q[c] == $past(wdata)));

        // R7
        mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !mask_wr[c] |=> $stable(mask_q[c]));
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int LINES        = 64,
    parameter int CASCADE_LINE = 55
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LINES-1:0]   irq_lines,
    input  logic               legacy_irq,
    input  logic               csr_req,
    input  logic               csr_we,
    input  logic [OFFS_W-1:0]  csr_addr,
    input  logic [LINES-1:0]   csr_wdata,
    output logic [LINES-1:0]   csr_rdata,
    output logic               csr_err,
    output logic [NUM_CPU-1:0] cpu_irq
);

    logic [LINES-1:0]   raw_q;
    logic [LINES-1:0]   mask_q [NUM_CPU];
    logic [LINES-1:0]   view   [NUM_CPU];
    reg_sel_t           sel;
    logic [NUM_CPU-1:0] mask_wr;

    irq_raw_capture #(.LINES(LINES), .CASCADE_LINE(CASCADE_LINE)) u_raw (
        .clk(clk), .rst(rst), .lines_in(irq_lines),
        .cascade_in(legacy_irq), .raw_q(raw_q)
    );

    irq_csr_decode u_dec (
        .clk(clk), .rst(rst), .req(csr_req), .we(csr_we), .addr(csr_addr),
        .sel(sel), .mask_wr(mask_wr), .err_q(csr_err)
    );

    irq_mask_bank #(.LINES(LINES)) u_bank (
        .clk(clk), .rst(rst), .mask_wr(mask_wr), .wdata(csr_wdata),
        .raw_q(raw_q), .mask_q(mask_q), .view(view), .irq_out(cpu_irq)
    );

    always_comb begin
        csr_rdata = '0;
        if (csr_req && !csr_we) begin
            unique case (sel.kind)
                REG_MASK: csr_rdata = mask_q[sel.cpu];
                REG_VIEW: csr_rdata = view[sel.cpu];
                REG_RAW:  csr_rdata = raw_q;
                default:  csr_rdata = '0;
            endcase
        end
    end

    // R6
    quiet_lines_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_lines == '0 && !legacy_irq) |=> (cpu_irq == '0));

    // R8
    undecoded_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_req && !csr_we && sel.kind == REG_NONE) |-> (csr_rdata == '0));

endmodule

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_lines = '0;
    logic        legacy_irq = 1'b0;
    logic        csr_req = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        csr_err;
    logic [3:0]  cpu_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    irq_router i_irq_router (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .legacy_irq(legacy_irq),
        .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_err(csr_err),
        .cpu_irq(cpu_irq)
    );

    localparam logic [11:0] MASK_OFS [4] = '{12'h200, 12'h240, 12'h600, 12'h640};
    localparam logic [11:0] VIEW_OFS [4] = '{12'h280, 12'h2C0, 12'h680, 12'h6C0};
    localparam logic [11:0] RAW_OFS = 12'h300;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, one edge per access, return at next negedge
    task automatic csr_write(input logic [11:0] a, input logic [63:0] d);
        csr_req = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_req = 1'b0; csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic csr_read(input logic [11:0] a, output logic [63:0] d);
        csr_req = 1'b1; csr_we = 1'b0; csr_addr = a;
        #1 d = csr_rdata;
        @(negedge clk);
        csr_req = 1'b0;
    endtask

    task automatic set_lines(input logic [63:0] v, input logic lg);
        irq_lines = v; legacy_irq = lg;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        check("R9 cpu_irq after reset", {60'd0, cpu_irq}, 64'd0);
        check("R9 err after reset", {63'd0, csr_err}, 64'd0);
        for (int c = 0; c < 4; c++) begin
            csr_read(MASK_OFS[c], d);
            check("R9 mask clear", d, 64'd0);
        end
        csr_read(RAW_OFS, d);
        check("R9 raw clear", d, 64'd0);
    endtask

    task automatic t_raw_capture();
        logic [63:0] d;
        set_lines(64'h8000_0000_0000_0001, 1'b0);
        csr_read(RAW_OFS, d);
        check("R1 raw follows lines", d, 64'h8000_0000_0000_0001);
        check("R10 bit0 is line0", {63'd0, d[0]}, 64'd1);
        set_lines(64'h0000_00F0_0000_0000, 1'b0);
        csr_read(RAW_OFS, d);
        check("R1 raw clears dropped lines", d, 64'h0000_00F0_0000_0000);
        set_lines(64'd0, 1'b0);
        csr_read(RAW_OFS, d);
        check("R5 raw read zero", d, 64'd0);
    endtask

    task automatic t_cascade();
        logic [63:0] d;
        set_lines(64'd0, 1'b1);
        csr_read(RAW_OFS, d);
        check("R2 cascade sets bit 55", d, 64'h0080_0000_0000_0000);
        set_lines(64'h0080_0000_0000_0000, 1'b1);
        csr_read(RAW_OFS, d);
        check("R2 cascade or line 55", d, 64'h0080_0000_0000_0000);
        set_lines(64'd0, 1'b0);
        csr_read(RAW_OFS, d);
        check("R2 bit 55 clears", d, 64'd0);
    endtask

    task automatic t_mask_write();
        logic [63:0] d;
        logic [63:0] pat [4] = '{64'h1111_0000_0000_000F, 64'h2222_0000_0000_00F0,
                                 64'h4444_0000_0000_0F00, 64'h8888_0000_0000_F000};
        for (int c = 0; c < 4; c++) csr_write(MASK_OFS[c], pat[c]);
        for (int c = 0; c < 4; c++) begin
            csr_read(MASK_OFS[c], d);
            check("R3 mask readback", d, pat[c]);
        end
        csr_write(MASK_OFS[2], 64'hDEAD_BEEF_0000_0001);
        for (int c = 0; c < 4; c++) begin
            csr_read(MASK_OFS[c], d);
            check("R3 only target mask changes", d,
                  (c == 2) ? 64'hDEAD_BEEF_0000_0001 : pat[c]);
        end
    endtask

    task automatic t_view_and_outputs();
        logic [63:0] d;
        logic [63:0] m [4] = '{64'h0000_0000_0000_00FF, 64'h0000_0000_0000_FF00,
                               64'h0080_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF};
        for (int c = 0; c < 4; c++) csr_write(MASK_OFS[c], m[c]);
        set_lines(64'h0000_0000_0000_0101, 1'b0);
        check("R6 outputs for lines 0 and 8", {60'd0, cpu_irq}, 64'hB);
        for (int c = 0; c < 4; c++) begin
            csr_read(VIEW_OFS[c], d);
            check("R4 masked view", d, m[c] & 64'h0101);
        end
        set_lines(64'd0, 1'b1);
        check("R6 cascade reaches cpu2 and cpu3", {60'd0, cpu_irq}, 64'hC);
        csr_read(VIEW_OFS[2], d);
        check("R4 view of cascade", d, 64'h0080_0000_0000_0000);
        // mask write takes effect at the write edge
        csr_req = 1'b1; csr_we = 1'b1; csr_addr = MASK_OFS[2]; csr_wdata = 64'd0;
        #1 check("R6 output unchanged before edge", {60'd0, cpu_irq}, 64'hC);
        @(negedge clk);
        csr_req = 1'b0; csr_we = 1'b0;
        check("R6 output drops after mask write", {60'd0, cpu_irq}, 64'h8);
        set_lines(64'd0, 1'b0);
        check("R6 all low when idle", {60'd0, cpu_irq}, 64'h0);
    endtask

    task automatic t_readonly();
        logic [63:0] d;
        for (int c = 0; c < 4; c++) csr_write(MASK_OFS[c], 64'h0F0F);
        set_lines(64'h0003, 1'b0);
        for (int c = 0; c < 4; c++) csr_write(VIEW_OFS[c], 64'hFFFF_FFFF_FFFF_FFFF);
        csr_write(RAW_OFS, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R7 no err on listed offset", {63'd0, csr_err}, 64'd0);
        for (int c = 0; c < 4; c++) begin
            csr_read(MASK_OFS[c], d);
            check("R7 mask kept after RO write", d, 64'h0F0F);
        end
        csr_read(RAW_OFS, d);
        check("R7 raw kept after RO write", d, 64'h0003);
        set_lines(64'd0, 1'b0);
    endtask

    task automatic t_unlisted();
        logic [63:0] d;
        csr_read(12'h008, d);
        check("R8 unlisted reads zero", d, 64'd0);
        check("R8 err pulse", {63'd0, csr_err}, 64'd1);
        @(negedge clk);
        check("R8 err lasts one cycle", {63'd0, csr_err}, 64'd0);
        csr_read(12'h204, d);
        check("R8 misaligned reads zero", d, 64'd0);
        check("R8 misaligned err", {63'd0, csr_err}, 64'd1);
        csr_write(12'hFF8, 64'hFFFF);
        check("R8 unlisted write err", {63'd0, csr_err}, 64'd1);
        csr_read(MASK_OFS[0], d);
        check("R8 unlisted write changes no mask", d, 64'h0F0F);
        check("R8 listed access no err", {63'd0, csr_err}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_raw_capture();
        t_cascade();
        t_mask_write();
        t_view_and_outputs();
        t_readonly();
        t_unlisted();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule